// File: doc/BRIEF.md
# Sequential Multiply / Square-Root Unit

This block is a shared iterative arithmetic engine for a small signal-processing core. A one-cycle start command captures the operands and chooses the operation. That operation is either an unsigned 32x32 multiply giving a 64-bit product, or the integer square root of a 50-bit value giving a 25-bit root. The engine then advances one step per clock on its own, so the core can issue unrelated instructions meanwhile. The multiply needs 32 clocks. The square root needs 26 clocks: one preparation clock, then one root bit per clock.

A separate one-cycle load command copies the most recently completed result to the output register. Software spaces start and load far enough apart, filling with other work or no-ops. The operand inputs are looked at only while a start is being accepted, and the working registers sit at zero whenever no operation is running. The arithmetic therefore does not toggle while the unit is idle.

Top module: `seq_arith_unit`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `result_o` are all zero.
- R2: With `sqrt_sel_i` = 0, a completed operation yields the unsigned 64-bit product of `mul_a_i` and `mul_b_i`.
- R3: A multiply holds `busy_o` high for exactly 32 clock cycles after the start edge, then drops it.
- R4: With `sqrt_sel_i` = 1, a completed operation yields floor(sqrt(`radicand_i`)) in `result_o[24:0]`, with bits 63:25 zero.
- R5: A square root holds `busy_o` high for exactly 26 clock cycles after the start edge.
- R6: `load_i` high at a clock edge makes `result_o` take the last completed result on that edge. Without `load_i`, `result_o` holds its value.
- R7: A load issued while an operation is still running returns the result of the previous completed operation.
- R8: A start while busy abandons the running operation, whose result is never stored, and begins the new one with full latency.
- R9: Operand inputs are sampled only on the start edge, so changes during an operation do not alter its result. The working registers are zero whenever the unit is not busy.
- R10: `done_o` rises on the edge that completes an operation, stays high until the next start, and is never high together with `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start command, one cycle |
| sqrt_sel_i | input | 1 | Operation select at start: 0 multiply, 1 square root |
| mul_a_i | input | 32 | Multiplicand |
| mul_b_i | input | 32 | Multiplier |
| radicand_i | input | 50 | Square-root input |
| load_i | input | 1 | Load command, one cycle |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Last operation finished |
| result_o | output | 64 | Loaded result |

## Verification
The bench targets a load that lands mid-operation. A design that forwarded partial state would return a half-formed product instead of the previous answer. It also restarts an operation part way through. A unit that kept the old count would finish early, and one that committed the abandoned result would expose it to the next load. After every start the operand pins are scrambled, which catches a datapath that reads its inputs live. Extremes are covered too: a full-scale multiply of all ones, and roots of zero and of the largest 50-bit value. These expose carry loss in the top partial sums and an off-by-one in the root bit count.

// File: rtl/sau_pkg.sv
package sau_pkg;
  localparam int MUL_W      = 32;
  localparam int RAD_W      = 50;
  localparam int ROOT_W     = RAD_W / 2;
  localparam int RES_W      = 2 * MUL_W;
  localparam int MUL_STEPS  = MUL_W;
  localparam int SQRT_STEPS = ROOT_W + 1;
  localparam int MAX_STEPS  = (MUL_STEPS > SQRT_STEPS) ? MUL_STEPS : SQRT_STEPS;
  localparam int CNT_W      = $clog2(MAX_STEPS + 1);
  localparam int ACC_W      = ((MUL_W + 1) > (ROOT_W + 2)) ? (MUL_W + 1) : (ROOT_W + 2);
  localparam int SHF_W      = (MUL_W > RAD_W) ? MUL_W : RAD_W;
  localparam int AUX_W      = (MUL_W > ROOT_W) ? MUL_W : ROOT_W;

  typedef enum logic {OP_MUL = 1'b0, OP_SQRT = 1'b1} sau_op_e;

  // acc: product high half / partial remainder
  // shf: product low half + multiplier / radicand being consumed
  // aux: multiplicand / root being built
  typedef struct packed {
    logic [ACC_W-1:0] acc;
    logic [SHF_W-1:0] shf;
    logic [AUX_W-1:0] aux;
  } sau_state_t;

  function automatic sau_state_t mul_step(input sau_state_t s);
    sau_state_t n;
    logic [MUL_W:0] addend;
    logic [MUL_W:0] sum;
    addend = s.shf[0] ? {1'b0, s.aux[MUL_W-1:0]} : '0;
    sum    = {1'b0, s.acc[MUL_W-1:0]} + addend;
    n      = '0;
    n.acc[MUL_W-1:0] = sum[MUL_W:1];
    n.shf[MUL_W-1:0] = {sum[0], s.shf[MUL_W-1:1]};
    n.aux  = s.aux;
    return n;
  endfunction

  function automatic sau_state_t sqrt_step(input sau_state_t s);
    sau_state_t n;
    logic [ROOT_W+2:0] rem_sh;
    logic [ROOT_W+2:0] trial;
    logic [ROOT_W+2:0] rem_nx;
    logic              bit_nx;
    rem_sh = {s.acc[ROOT_W:0], s.shf[RAD_W-1 -: 2]};
    trial  = {1'b0, s.aux[ROOT_W-1:0], 2'b01};
    bit_nx = (rem_sh >= trial);
    rem_nx = bit_nx ? (rem_sh - trial) : rem_sh;
    n      = '0;
    n.acc[ROOT_W:0]    = rem_nx[ROOT_W:0];
    n.shf              = s.shf << 2;
    n.aux[ROOT_W-1:0]  = {s.aux[ROOT_W-2:0], bit_nx};
    return n;
  endfunction

  function automatic logic [RES_W-1:0] mul_result(input sau_state_t s);
    return {s.acc[MUL_W-1:0], s.shf[MUL_W-1:0]};
  endfunction

  function automatic logic [RES_W-1:0] sqrt_result(input sau_state_t s);
    return RES_W'(s.aux[ROOT_W-1:0]);
  endfunction
endpackage

// File: rtl/sau_ctrl.sv
module sau_ctrl
  import sau_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             sqrt_sel_i,
  output logic             busy_o,
  output logic             done_o,
  output sau_op_e          op_o,
  output logic             step_en_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;
  sau_op_e          op_q;
  logic             setup_cyc;
  logic             abort_ev;

  assign setup_cyc = busy_q && (op_q == OP_SQRT) && (cnt_q == CNT_W'(SQRT_STEPS));
  assign last_o    = busy_q && (cnt_q == CNT_W'(1));
  assign step_en_o = busy_q && !setup_cyc;
  assign abort_ev  = start_i && busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      op_q   <= OP_MUL;
    end else if (start_i) begin
      op_q   <= sqrt_sel_i ? OP_SQRT : OP_MUL;
      cnt_q  <= sqrt_sel_i ? CNT_W'(SQRT_STEPS) : CNT_W'(MUL_STEPS);
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (last_o) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign op_o   = op_q;

  p_cnt_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q != '0) && (cnt_q <= CNT_W'(MAX_STEPS)));
  p_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q));
  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start_i) |=> done_q);
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> busy_q && !done_q);
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_q && !done_q);
endmodule

// File: rtl/sau_datapath.sv
module sau_datapath
  import sau_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             sqrt_sel_i,
  input  logic [MUL_W-1:0] mul_a_i,
  input  logic [MUL_W-1:0] mul_b_i,
  input  logic [RAD_W-1:0] radicand_i,
  input  logic             busy_i,
  input  sau_op_e          op_i,
  input  logic             step_en_i,
  input  logic             last_i,
  output logic [RES_W-1:0] res_hold_o
);
  sau_state_t       st_q, st_nxt, st_init;
  logic [RES_W-1:0] res_q, res_fin;
  logic [MUL_W-1:0] a_iso, b_iso;
  logic [RAD_W-1:0] r_iso;
  logic             commit_ev;

  // operand isolation: inputs reach the datapath only on a start edge
  assign a_iso = (start_i && !sqrt_sel_i) ? mul_a_i    : '0;
  assign b_iso = (start_i && !sqrt_sel_i) ? mul_b_i    : '0;
  assign r_iso = (start_i &&  sqrt_sel_i) ? radicand_i : '0;

  always_comb begin
    st_init = '0;
    if (sqrt_sel_i) begin
      st_init.shf[RAD_W-1:0] = r_iso;
    end else begin
      st_init.shf[MUL_W-1:0] = b_iso;
      st_init.aux[MUL_W-1:0] = a_iso;
    end
  end

  always_comb begin
    if (!step_en_i)          st_nxt = st_q;
    else if (op_i == OP_SQRT) st_nxt = sqrt_step(st_q);
    else                     st_nxt = mul_step(st_q);
  end

  assign res_fin   = (op_i == OP_SQRT) ? sqrt_result(st_nxt) : mul_result(st_nxt);
  assign commit_ev = last_i && !start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      res_q <= '0;
    end else if (start_i) begin
      st_q <= st_init;
    end else if (busy_i) begin
      if (last_i) begin
        st_q  <= '0;
        res_q <= res_fin;
      end else begin
        st_q <= st_nxt;
      end
    end
  end

  assign res_hold_o = res_q;

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |-> (st_q == '0));
  p_res_only_on_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_ev |=> $stable(res_q));
  p_sqrt_high_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_ev && op_i == OP_SQRT) |=> (res_q[RES_W-1:ROOT_W] == '0));
endmodule

// File: rtl/seq_arith_unit.sv
module seq_arith_unit
  import sau_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             sqrt_sel_i,
  input  logic [31:0]      mul_a_i,
  input  logic [31:0]      mul_b_i,
  input  logic [49:0]      radicand_i,
  input  logic             load_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [63:0]      result_o
);
  sau_op_e          op_w;
  logic             step_en_w, last_w, busy_w;
  logic [RES_W-1:0] res_hold_w;
  logic [RES_W-1:0] result_q;

  sau_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .sqrt_sel_i(sqrt_sel_i),
    .busy_o    (busy_w),
    .done_o    (done_o),
    .op_o      (op_w),
    .step_en_o (step_en_w),
    .last_o    (last_w)
  );

  sau_datapath u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .sqrt_sel_i(sqrt_sel_i),
    .mul_a_i   (mul_a_i),
    .mul_b_i   (mul_b_i),
    .radicand_i(radicand_i),
    .busy_i    (busy_w),
    .op_i      (op_w),
    .step_en_i (step_en_w),
    .last_i    (last_w),
    .res_hold_o(res_hold_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      result_q <= '0;
    else if (load_i) result_q <= res_hold_w;
  end

  assign busy_o   = busy_w;
  assign result_o = result_q;

  p_load_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(result_q));
  p_load_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (result_q == $past(res_hold_w)));
  p_load_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && busy_w && !last_w) |=> (result_q == res_hold_w));
endmodule

// File: tb/seq_arith_unit_tb.sv
`timescale 1ns/1ps
module seq_arith_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, sqrt_sel_i = 1'b0, load_i = 1'b0;
  logic [31:0] mul_a_i = '0, mul_b_i = '0;
  logic [49:0] radicand_i = '0;
  logic        busy_o, done_o;
  logic [63:0] result_o;

  int n_run = 0, n_fail = 0;
  logic        summary_done = 1'b0;

  always #2.5 clk = ~clk;

  seq_arith_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sqrt_sel_i(sqrt_sel_i),
    .mul_a_i(mul_a_i), .mul_b_i(mul_b_i), .radicand_i(radicand_i),
    .load_i(load_i), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_isqrt(input logic [49:0] x);
    logic [63:0] r = 0;
    for (int b = 24; b >= 0; b--) begin
      logic [63:0] t = r | (64'd1 << b);
      if (t * t <= {14'd0, x}) r = t;
    end
    return r;
  endfunction

  // behavioural reference model
  bit          m_busy = 0, m_done = 0;
  int          m_cnt = 0;
  logic [63:0] m_pend = 0, m_hold = 0, m_res = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_pend = 0; m_hold = 0; m_res = 0;
    end else begin
      if (load_i) m_res = m_hold;
      if (start_i) begin
        m_busy = 1; m_done = 0;
        m_cnt  = sqrt_sel_i ? 26 : 32;
        m_pend = sqrt_sel_i ? ref_isqrt(radicand_i) : ({32'd0, mul_a_i} * {32'd0, mul_b_i});
      end else if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1; m_hold = m_pend;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !summary_done) begin
      chk("R3/R5 busy", {63'd0, busy_o}, {63'd0, m_busy});
      chk("R10 done", {63'd0, done_o}, {63'd0, m_done});
      chk("R6 result", result_o, m_res);
    end
  end

  task automatic pulse_start(input bit sq, input logic [31:0] a, input logic [31:0] b,
                             input logic [49:0] r);
    start_i = 1; sqrt_sel_i = sq; mul_a_i = a; mul_b_i = b; radicand_i = r;
    @(negedge clk);
    start_i = 0;
    // scramble operands while running (R9)
    mul_a_i = $urandom; mul_b_i = $urandom; radicand_i = {$urandom, $urandom};
  endtask

  task automatic do_load();
    load_i = 1;
    @(negedge clk);
    load_i = 0;
  endtask

  task automatic run_op(input bit sq, input logic [31:0] a, input logic [31:0] b,
                        input logic [49:0] r, input logic [63:0] exp, input string tag);
    int n = 0;
    pulse_start(sq, a, b, r);
    while (busy_o) begin
      n++;
      @(negedge clk);
    end
    chk(sq ? "R5 latency" : "R3 latency", 64'(n), sq ? 64'd26 : 64'd32);
    chk("R10 done after op", {63'd0, done_o}, 64'd1);
    do_load();
    chk(tag, result_o, exp);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary_done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", {63'd0, busy_o}, 64'd0);
    chk("R1 done", {63'd0, done_o}, 64'd0);
    chk("R1 result", result_o, 64'd0);
    rst_n = 1;
    @(negedge clk);

    run_op(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 64'hFFFF_FFFE_0000_0001, "R2 max product");
    run_op(0, 32'd12345, 32'd6789, 0, 64'd83810205, "R2 small product");
    run_op(0, 32'd0, 32'hDEAD_BEEF, 0, 64'd0, "R2 zero operand");
    run_op(0, 32'h8000_0000, 32'd3, 0, 64'h1_8000_0000, "R2 msb operand");
    run_op(1, 0, 0, 50'h3_FFFF_FFFF_FFFF, 64'h1FF_FFFF, "R4 max root");
    run_op(1, 0, 0, 50'd0, 64'd0, "R4 zero root");
    run_op(1, 0, 0, 50'd144, 64'd12, "R4 exact square");
    run_op(1, 0, 0, 50'd143, 64'd11, "R4 floor");
    run_op(0, 32'd2, 32'd3, 0, 64'd6, "R9 operands changed during run");

    // R10: done sticks until next start
    repeat (10) @(negedge clk);
    chk("R10 done sticky", {63'd0, done_o}, 64'd1);

    // R7: load while busy returns previous result (6)
    pulse_start(0, 32'd7, 32'd6, 0);
    chk("R10 done cleared by start", {63'd0, done_o}, 64'd0);
    repeat (4) @(negedge clk);
    do_load();
    chk("R7 load while busy", result_o, 64'd6);
    while (busy_o) @(negedge clk);
    do_load();
    chk("R2 after early load", result_o, 64'd42);

    // R8: restart mid-operation
    pulse_start(0, 32'd3, 32'd5, 0);
    repeat (9) @(negedge clk);
    run_op(0, 32'd10, 32'd10, 0, 64'd100, "R8 restart result");
    pulse_start(1, 0, 0, 50'd1000000);
    repeat (20) @(negedge clk);
    run_op(0, 32'd9, 32'd9, 0, 64'd81, "R8 sqrt aborted by multiply");

    // mixed random traffic, model compared every cycle
    for (int i = 0; i < 24; i++) begin
      bit          sq = $urandom_range(0, 1);
      logic [31:0] a = $urandom, b = $urandom;
      logic [49:0] r = {$urandom, $urandom};
      run_op(sq, a, b, r, sq ? ref_isqrt(r) : ({32'd0, a} * {32'd0, b}),
             sq ? "R4 random" : "R2 random");
    end

    repeat (3) @(negedge clk);
    summary_done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule